// File: doc/BRIEF.md
# Multi-Mode Reloadable Down-Counting Timer

This block is a down-counting timer with a reload value and a control word, both set through a small word-wide register bus. The control word chooses where the counter's decrements come from. In internal mode each pulse of an external prescaler enable decrements it. In external mode each selected edge of an asynchronous pin decrements it, after the pin has passed through a two-flop synchronizer. In pulse-width mode prescaler pulses decrement it only while the synchronized pin sits at the chosen level. One polarity bit serves two purposes: it selects the edge in external mode and the level in pulse-width mode.

When the counter is at zero and takes one more decrement, it underflows. It then reloads and emits a one-cycle underflow pulse. That pulse sets a sticky interrupt flag and toggles a serial clock output. In repeat mode the timer keeps running after an underflow. In one-shot mode it stops itself at the underflow. Software can restart the count from the reload value, and it can start or stop the timer, through the control word.

Register map, one 16-bit word at each address: 0 control, 1 reload value, 2 live counter (read-only), 3 status (bit 0 is the interrupt flag; writing 1 clears it).

Top module: `mm_down_timer`

## Requirements
- R1: Control word fields are bit 0 run, bit 1 software reset (write-only, always reads 0), bit 4 one-shot, bits 9:8 mode and bit 10 polarity. Every other bit reads 0. After reset the control word reads 0x0400.
- R2: In mode 0 the counter decrements on each cycle where `tick_i` is high and the timer is running. From zero, one further tick causes an underflow.
- R3: In mode 1 the counter decrements once per edge of `ext_i`, detected after a two-flop synchronizer. Polarity 1 selects the rising edge and polarity 0 selects the falling edge.
- R4: In mode 2 the counter decrements on a `tick_i` cycle only while the synchronized `ext_i` equals the polarity bit (1 means high, 0 means low).
- R5: In mode 3 the counter does not change.
- R6: At underflow the counter reloads from the reload value. With one-shot set to 0 the timer keeps running. With one-shot set to 1 the run bit clears.
- R7: Writing the control word with bit 1 set loads the reload value into the counter and suppresses counting in that cycle. The run bit still takes the value written. Writing bit 1 as 0 has no effect on the counter.
- R8: While the run bit is 0 the counter holds its value.
- R9: `uf_o` is high for exactly one cycle per underflow, and `sclk_o` toggles at each underflow.
- R10: `irq_o` is set by an underflow and stays set until status bit 0 is written as 1. Writing 0 to that bit leaves the flag unchanged, and an underflow wins over a clear in the same cycle.
- R11: Writing address 1 changes the reload value, which reads back zero-extended, and leaves the counter untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` (combinational) |
| tick_i | input | 1 | One-cycle prescaler enable |
| ext_i | input | 1 | Asynchronous external pin |
| uf_o | output | 1 | One-cycle underflow pulse |
| irq_o | output | 1 | Sticky interrupt flag |
| sclk_o | output | 1 | Serial clock, toggled per underflow |

## Verification
The bench builds the timer with an 8-bit counter and a reload value of 5, so that underflows, reloads and one-shot stops occur many times within a few hundred cycles. The prescaler enable pulses on one cycle in three. This places ticks at different phases relative to bus writes, pin edges and level changes. With the narrow counter, repeated wrap-and-reload, the end of a one-shot run and the interaction between a clear and an underflow all fall within a short run.

// File: rtl/mm_down_timer.sv
module mm_down_timer #(
  parameter int CNT_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  bus_addr_i,
  input  logic        bus_wr_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  input  logic        tick_i,
  input  logic        ext_i,
  output logic        uf_o,
  output logic        irq_o,
  output logic        sclk_o
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q, rld_q;
  logic [1:0]       mode_q;
  logic             pol_q, oneshot_q, run_q;
  logic             s1_q, s2_q, s3_q;
  logic             uf_q, irq_q, sclk_q;
  logic             cnt_en;

  wire wr_ctl = bus_wr_i && bus_addr_i == 2'd0;
  wire wr_rld = bus_wr_i && bus_addr_i == 2'd1;
  wire wr_st  = bus_wr_i && bus_addr_i == 2'd3;
  wire swrst  = wr_ctl && bus_wdata_i[1];
  wire rise   = s2_q & ~s3_q;
  wire fall   = ~s2_q & s3_q;

  always_comb begin
    case (mode_q)
      2'd0:    cnt_en = tick_i;
      2'd1:    cnt_en = pol_q ? rise : fall;
      2'd2:    cnt_en = tick_i && (s2_q == pol_q);
      default: cnt_en = 1'b0;
    endcase
  end

  wire step = run_q && cnt_en && !swrst;
  wire hit  = step && cnt_q == ZERO;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= ext_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q     <= 1'b1;
      mode_q    <= 2'd0;
      oneshot_q <= 1'b0;
      run_q     <= 1'b0;
      rld_q     <= '0;
    end else begin
      if (wr_ctl) begin
        pol_q     <= bus_wdata_i[10];
        mode_q    <= bus_wdata_i[9:8];
        oneshot_q <= bus_wdata_i[4];
        run_q     <= bus_wdata_i[0];
      end else if (hit && oneshot_q) begin
        run_q <= 1'b0;
      end
      if (wr_rld) rld_q <= bus_wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      uf_q   <= 1'b0;
      irq_q  <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      if (swrst)     cnt_q <= rld_q;
      else if (hit)  cnt_q <= rld_q;
      else if (step) cnt_q <= cnt_q - 1'b1;
      uf_q <= hit;
      if (hit) sclk_q <= ~sclk_q;
      if (hit) irq_q <= 1'b1;
      else if (wr_st && bus_wdata_i[0]) irq_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr_i)
      2'd0:    bus_rdata_o = {5'b0, pol_q, mode_q, 3'b0, oneshot_q, 3'b0, run_q};
      2'd1:    bus_rdata_o = 16'(rld_q);
      2'd2:    bus_rdata_o = 16'(cnt_q);
      default: bus_rdata_o = {15'b0, irq_q};
    endcase
  end

  assign uf_o   = uf_q;
  assign irq_o  = irq_q;
  assign sclk_o = sclk_q;

  AST_CTL_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i == 2'd0 |-> bus_rdata_o[15:11] == 5'b0 && bus_rdata_o[7:5] == 3'b0 && bus_rdata_o[3:1] == 3'b0); // R1
  AST_UF_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_o |-> $past(cnt_q) == ZERO); // R2
  AST_MODE3_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_q == 2'd3 && !wr_ctl) |-> cnt_q == $past(cnt_q)); // R5
  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_o && $past(oneshot_q && !wr_ctl) |-> !run_q); // R6
  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!run_q && !wr_ctl) |-> cnt_q == $past(cnt_q)); // R8
  AST_UF_SCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_o |-> sclk_o != $past(sclk_o)); // R9
  AST_IRQ_ON_UF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_o |-> irq_o); // R10
endmodule

// File: tb/mm_down_timer_tb.sv
module mm_down_timer_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  addr = 2'd2;
  logic        wr = 1'b0, tick = 1'b0, ext = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        uf, irq, sclk;
  int total = 0, bad = 0, cyc_n = 0, ph = 0;
  bit tick_on = 0, done = 0;

  int m_cnt, m_rld, m_mode, m_pol, m_os, m_run, m_uf, m_irq, m_sclk;
  int eh[$];

  always #10 clk = ~clk;

  mm_down_timer #(.CNT_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tick_i(tick), .ext_i(ext),
    .uf_o(uf), .irq_o(irq), .sclk_o(sclk));

  function automatic int m_read(int a);
    case (a)
      0: return (m_pol << 10) | (m_mode << 8) | (m_os << 4) | m_run;
      1: return m_rld;
      2: return m_cnt;
      default: return m_irq;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_rld = 0; m_mode = 0; m_pol = 1; m_os = 0; m_run = 0;
      m_uf = 0; m_irq = 0; m_sclk = 0; eh = '{0, 0, 0};
    end else begin
      int lv, pv, en, sw, fire;
      lv = eh[1]; pv = eh[2];
      sw = (wr && addr == 0 && wdata[1]) ? 1 : 0;
      case (m_mode)
        0: en = tick;
        1: en = m_pol ? (lv == 1 && pv == 0) : (lv == 0 && pv == 1);
        2: en = tick && (lv == m_pol);
        default: en = 0;
      endcase
      fire = (m_run && en && !sw && m_cnt == 0) ? 1 : 0;
      if (sw || fire) m_cnt = m_rld;
      else if (m_run && en) m_cnt = m_cnt - 1;
      if (fire) begin m_sclk = 1 - m_sclk; m_irq = 1; end
      else if (wr && addr == 3 && wdata[0]) m_irq = 0;
      if (wr && addr == 0) begin
        m_pol = wdata[10]; m_mode = wdata[9:8]; m_os = wdata[4]; m_run = wdata[0];
      end else if (fire && m_os) m_run = 0;
      if (wr && addr == 1) m_rld = wdata[7:0];
      m_uf = fire;
      eh.push_front(int'(ext)); void'(eh.pop_back());
    end
  end

  always @(negedge clk) begin
    ph = (ph + 1) % 3;
    tick = tick_on && ph == 0;
    cyc_n++;
    if (rst_n) begin
      total += 3;
      if (uf != m_uf[0]) begin bad++; $display("FAIL R9 uf act=%0d exp=%0d", uf, m_uf); end
      if (sclk != m_sclk[0]) begin bad++; $display("FAIL R9 sclk act=%0d exp=%0d", sclk, m_sclk); end
      if (irq != m_irq[0]) begin bad++; $display("FAIL R10 irq act=%0d exp=%0d", irq, m_irq); end
    end
    if (cyc_n > 20000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc_n);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk); addr = a[1:0]; #1;
    total++;
    if (rdata != exp[15:0]) begin
      bad++; $display("FAIL %s addr=%0d act=%h exp=%h", tag, a, rdata, exp[15:0]);
    end
  endtask

  task automatic rdm(input int a, input string tag);
    @(negedge clk); addr = a[1:0]; #1;
    total++;
    if (rdata != m_read(a)) begin
      bad++; $display("FAIL %s addr=%0d act=%h exp=%h", tag, a, rdata, m_read(a));
    end
  endtask

  task automatic wrr(input int a, input int d);
    @(negedge clk); #2; addr = a[1:0]; wdata = d[15:0]; wr = 1'b1;
    @(negedge clk); #2; wr = 1'b0; addr = 2'd2;
  endtask

  task automatic run_cnt(input int n, input int per, input string tag);
    for (int i = 0; i < n; i++) begin
      if (per > 0) ext = ((i / per) % 2) != 0;
      rdm(2, tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(0, 16'h0400, "R1 reset ctl");
    rd(3, 0, "R10 reset irq");
    wrr(1, 16'hFF05);
    rd(1, 5, "R11 reload readback");
    rd(2, 0, "R11 counter untouched");
    wrr(0, 16'h0402);
    rd(2, 5, "R7 swreset load");
    rd(0, 16'h0400, "R1 reset bit reads 0");
    wrr(1, 7);
    wrr(0, 16'h0400);
    rd(2, 5, "R7 bit1=0 no effect");
    wrr(1, 5);
    tick_on = 1;
    wrr(0, 16'h0401);
    run_cnt(60, 0, "R2 R6 internal repeat");
    rdm(0, "R6 repeat still running");
    wrr(3, 0);
    rd(3, 1, "R10 write 0 ignored");
    wrr(0, 16'h0400);
    wrr(3, 1);
    rd(3, 0, "R10 clear");
    run_cnt(10, 0, "R8 stopped hold");
    wrr(0, 16'h0413);
    run_cnt(40, 0, "R6 one-shot");
    rd(0, 16'h0410, "R6 one-shot run cleared");
    tick_on = 0;
    wrr(0, 16'h0503);
    run_cnt(80, 2, "R3 external rising");
    wrr(0, 16'h0103);
    run_cnt(80, 3, "R3 external falling");
    ext = 0;
    tick_on = 1;
    wrr(0, 16'h0603);
    run_cnt(90, 10, "R4 pulse high");
    wrr(0, 16'h0203);
    run_cnt(90, 7, "R4 pulse low");
    wrr(0, 16'hFFFF);
    rd(0, 16'h0711, "R1 reserved bits zero");
    run_cnt(40, 4, "R5 mode3 hold");
    wrr(3, 1);
    rdm(3, "R10 clear after run");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule